// File: doc/BRIEF.md
# Configurable Burst Read Address Sequencer

This block produces the order of double-word addresses that a synchronous burst read walks through in a parallel memory array. A small configuration register chooses the ordering (sequential or interleaved), the burst length (4, 8 or endless), whether the burst is held inside its aligned block or runs past it, and which edge of the burst clock advances it. The block runs on a fast system clock. It samples the slower burst clock and turns each configured edge into a one-cycle advance tick.

Software or a command decoder writes the register. A read controller then pulses `start` with the first address. On every active burst-clock edge the sequencer does one of two things. It delivers the next address with a one-cycle `valid` pulse. Or, for linear bursts that began off an 8-word boundary, it raises `wait_o` for that edge while it crosses each 8-word boundary and holds the address. If the configuration is illegal, the start request is dropped.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset the register reads 0x00C1 (sequential, rising edge, wrapping, length 4), `valid` and `wait_o` are low, and `cfg_illegal` is low.
- R2: Only bits [3:0], 6 and 7 are stored. Every other bit, including the reserved bits 10, 5 and 4, is ignored on write and reads back as 0.
- R3: Bit 6 selects the advancing burst-clock edge: 1 = rising, 0 = falling. A transition on the other edge causes no delivery.
- R4: With bit 3 = 0, bit 7 = 1 (sequential) and length field bits [2:0] = 001 (4) or 010 (8), the burst delivers exactly L addresses. Each one keeps the upper bits of the start address, and the low log2(L) bits count up from the start value modulo L.
- R5: With bit 7 = 0 (interleaved) and a wrapping length of 4 or 8, beat i delivers the start address with its low log2(L) bits XORed with i. The burst stops after L beats.
- R6: With bit 3 = 1 (no wrap) and a length of 4 or 8, the burst delivers L linearly incrementing addresses that may cross the aligned block, and then stops.
- R7: Length field 111 with sequential order gives a continuous linear burst. It keeps going until a new start, and it wraps modulo 2^19.
- R8: A linear (no-wrap or continuous) burst whose start address has bits [2:0] = 0 never raises `wait_o`.
- R9: A linear burst with an unaligned start raises `wait_o` for exactly one active edge before each address whose bits [2:0] are 0 (after the first beat). During that edge no address is delivered and `addr` holds.
- R10: A length field other than 001, 010 or 111, or 111 combined with interleaved order, drives `cfg_illegal` high, and `start` is then ignored.
- R11: A `start` during an active burst abandons it and begins a new burst from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the burst clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration register read value |
| cfg_illegal | output | 1 | Current configuration is not a legal burst setting |
| start | input | 1 | One-cycle burst start request |
| start_addr | input | 19 | First double-word address of the burst |
| bclk | input | 1 | Burst clock, asynchronous to clk |
| addr | output | 19 | Last delivered array address |
| valid | output | 1 | One-cycle pulse: `addr` carries a new beat |
| wait_o | output | 1 | One-cycle pulse: an edge was spent on a boundary delay |

## Verification
The assertions assume that `bclk` stays at each level for at least three system-clock cycles, so that every active edge yields exactly one isolated tick. They also assume that `bclk` is low out of reset, so no edge appears spuriously. The bench holds each burst-clock level for six system cycles and keeps `bclk` low through reset. It drives `start`, `cfg_we` and the burst clock only on falling system-clock edges. It writes the register before issuing `start`, never in the same cycle, so every burst latches a settled configuration.

// File: rtl/burst_seq_pkg.sv
// Package: shared configuration type, field positions and length codes
// for the burst address sequencer. Assumes a 16-bit register image.
package burst_seq_pkg;

    localparam int CFG_W     = 16;
    localparam int POS_NOWRP = 3;
    localparam int POS_EDGE  = 6;
    localparam int POS_SEQ   = 7;

    localparam logic [2:0] LEN_FOUR  = 3'b001;
    localparam logic [2:0] LEN_EIGHT = 3'b010;
    localparam logic [2:0] LEN_CONT  = 3'b111;

    localparam logic [CFG_W-1:0] CFG_RESET = 16'h00C1;

    typedef struct packed {
        logic       seq;       // 1 = sequential, 0 = interleaved
        logic       edge_rise; // 1 = rising burst-clock edge active
        logic       nowrap;    // 1 = run past the aligned block
        logic [2:0] len;       // burst length code
    } burst_cfg_t;

endpackage

// File: rtl/burst_cfg_reg.sv
// Configuration register: stores only the implemented fields, reads back
// zero elsewhere, and flags illegal length/order combinations.
// Assumes writes are single-cycle strobes in the clk domain.
module burst_cfg_reg
    import burst_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output burst_cfg_t       cfg,
    output logic             illegal
);

    burst_cfg_t cfg_q;

    // Capture implemented fields on a write; reset to the default image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.seq       <= CFG_RESET[POS_SEQ];
            cfg_q.edge_rise <= CFG_RESET[POS_EDGE];
            cfg_q.nowrap    <= CFG_RESET[POS_NOWRP];
            cfg_q.len       <= CFG_RESET[2:0];
        end else if (we) begin
            cfg_q.seq       <= wdata[POS_SEQ];
            cfg_q.edge_rise <= wdata[POS_EDGE];
            cfg_q.nowrap    <= wdata[POS_NOWRP];
            cfg_q.len       <= wdata[2:0];
        end
    end

    // Assemble the read image with unimplemented bits tied to zero.
    always_comb begin
        rdata            = '0;
        rdata[2:0]       = cfg_q.len;
        rdata[POS_NOWRP] = cfg_q.nowrap;
        rdata[POS_EDGE]  = cfg_q.edge_rise;
        rdata[POS_SEQ]   = cfg_q.seq;
    end

    // Decide legality of the length code against the ordering.
    always_comb begin
        unique case (cfg_q.len)
            LEN_FOUR, LEN_EIGHT: illegal = 1'b0;
            LEN_CONT:            illegal = !cfg_q.seq;
            default:             illegal = 1'b1;
        endcase
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/burst_edge_det.sv
// Burst-clock edge detector: brings the asynchronous burst clock into the
// system domain through two flops and emits a one-cycle tick on the
// configured edge. Assumes each bclk level lasts at least three clk cycles
// and that bclk is low while reset is applied.
module burst_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic edge_rise,
    output logic tick
);

    logic sync1_q, sync2_q, prev_q;

    // Synchronise the burst clock and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= bclk;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    // Pick the rising or falling transition as the active tick.
    always_comb begin
        tick = edge_rise ? (sync2_q & ~prev_q) : (~sync2_q & prev_q);
    end

    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R3

endmodule

// File: rtl/burst_seq_gen.sv
// Address generator: latches the configuration at start, then on each
// active tick delivers the next beat address (wrap or linear order) or
// spends the tick on a boundary delay. Assumes start is a one-cycle pulse
// gated by legality and that ADDR_W is at least 4.
module burst_seq_gen
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic [ADDR_W-1:0] start_addr,
    input  burst_cfg_t        cfg,
    input  logic              tick,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o,
    output logic              wait_o
);

    localparam int BLK_W = 3;

    logic              active_q, wrap_q, seq_q, len8_q, cont_q;
    logic              unaligned_q, first_q, stalled_q;
    logic [ADDR_W-1:0] base_q, cur_q, addr_q;
    logic [BEAT_W-1:0] beat_q;
    logic              valid_q, wait_q;

    logic [BLK_W-1:0]  lo_mask, lo_off;
    logic [ADDR_W-1:0] wrap_addr;
    logic [BEAT_W-1:0] last_beat;
    logic              need_stall;

    // Form the in-block offset for wrapping bursts of either ordering.
    always_comb begin
        lo_mask   = len8_q ? 3'b111 : 3'b011;
        if (seq_q) lo_off = (base_q[BLK_W-1:0] + beat_q[BLK_W-1:0]) & lo_mask;
        else       lo_off = (base_q[BLK_W-1:0] ^ beat_q[BLK_W-1:0]) & lo_mask;
        wrap_addr = {base_q[ADDR_W-1:BLK_W], (base_q[BLK_W-1:0] & ~lo_mask) | lo_off};
        last_beat = len8_q ? BEAT_W'(7) : BEAT_W'(3);
    end

    // Decide whether this tick must be spent crossing an 8-word boundary.
    always_comb begin
        need_stall = unaligned_q && !first_q && !stalled_q
                     && (cur_q[BLK_W-1:0] == '0);
    end

    // Burst state: load on start, advance or stall on each active tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q    <= 1'b0;
            wrap_q      <= 1'b0;
            seq_q       <= 1'b0;
            len8_q      <= 1'b0;
            cont_q      <= 1'b0;
            unaligned_q <= 1'b0;
            first_q     <= 1'b0;
            stalled_q   <= 1'b0;
            base_q      <= '0;
            cur_q       <= '0;
            addr_q      <= '0;
            beat_q      <= '0;
            valid_q     <= 1'b0;
            wait_q      <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            wait_q  <= 1'b0;
            if (start_ok) begin
                active_q    <= 1'b1;
                cont_q      <= (cfg.len == LEN_CONT);
                wrap_q      <= !cfg.nowrap && (cfg.len != LEN_CONT);
                seq_q       <= cfg.seq;
                len8_q      <= (cfg.len == LEN_EIGHT);
                unaligned_q <= (start_addr[BLK_W-1:0] != '0);
                first_q     <= 1'b1;
                stalled_q   <= 1'b0;
                base_q      <= start_addr;
                cur_q       <= start_addr;
                beat_q      <= '0;
            end else if (tick && active_q) begin
                if (wrap_q) begin
                    addr_q  <= wrap_addr;
                    valid_q <= 1'b1;
                    beat_q  <= beat_q + 1'b1;
                    if (beat_q == last_beat) active_q <= 1'b0;
                end else if (need_stall) begin
                    wait_q    <= 1'b1;
                    stalled_q <= 1'b1;
                end else begin
                    addr_q    <= cur_q;
                    valid_q   <= 1'b1;
                    cur_q     <= cur_q + 1'b1;
                    stalled_q <= 1'b0;
                    first_q   <= 1'b0;
                    if (!cont_q) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == last_beat) active_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign addr_o  = addr_q;
    assign valid_o = valid_q;
    assign wait_o  = wait_q;

    AST_BEAT_OR_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> !wait_q); // R9
    AST_DELAY_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q |-> $stable(addr_q)); // R9
    AST_ALIGNED_NO_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        !unaligned_q |-> !wait_q); // R8
    AST_WRAP_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && wrap_q) |-> (addr_q[ADDR_W-1:BLK_W] == base_q[ADDR_W-1:BLK_W])); // R4
    AST_BEAT_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(tick)); // R3

endmodule

// File: rtl/burst_addr_seq.sv
// Top: configuration register, burst-clock edge detector and address
// generator. Assumes a system clock at least six times the burst clock.
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    output logic              cfg_illegal,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              bclk,
    output logic [ADDR_W-1:0] addr,
    output logic              valid,
    output logic              wait_o
);

    burst_cfg_t cfg;
    logic       tick;
    logic       start_ok;

    burst_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .cfg     (cfg),
        .illegal (cfg_illegal)
    );

    burst_edge_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (bclk),
        .edge_rise (cfg.edge_rise),
        .tick      (tick)
    );

    // Drop start requests while the configuration is illegal.
    always_comb begin
        start_ok = start && !cfg_illegal;
    end

    burst_seq_gen #(.ADDR_W(ADDR_W), .BEAT_W(4)) u_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_ok   (start_ok),
        .start_addr (start_addr),
        .cfg        (cfg),
        .tick       (tick),
        .addr_o     (addr),
        .valid_o    (valid),
        .wait_o     (wait_o)
    );

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

    localparam int AW   = 19;
    localparam int MASK = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [15:0]   cfg_wdata = '0;
    logic [15:0]   cfg_rdata;
    logic          cfg_illegal;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          bclk = 1'b0;
    logic [AW-1:0] addr;
    logic          valid, wait_o;

    int checks = 0;
    int failures = 0;
    int ev[$];
    int ex[$];

    always #2.5 clk = ~clk;

    burst_addr_seq i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .cfg_illegal(cfg_illegal), .start(start),
        .start_addr(start_addr), .bclk(bclk), .addr(addr), .valid(valid),
        .wait_o(wait_o)
    );

    // Record delivered addresses, and -1 for each delay edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (valid)  ev.push_back(int'(addr));
            if (wait_o) ev.push_back(-1);
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic do_start(input int a);
        @(negedge clk); start = 1'b1; start_addr = AW'(a);
        @(negedge clk); start = 1'b0;
        ev.delete(); ex.delete();
    endtask

    task automatic bclk_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            bclk = 1'b1; repeat (6) @(negedge clk);
            bclk = 1'b0; repeat (6) @(negedge clk);
        end
    endtask

    task automatic exp_wrap(input int s, input int len, input bit seq);
        int lo;
        lo = s & (len - 1);
        for (int i = 0; i < len; i++)
            ex.push_back((s & ~(len - 1)) | (seq ? ((lo + i) % len) : (lo ^ i)));
    endtask

    task automatic exp_linear(input int s, input int ticks, input int limit);
        int a, got, t;
        bit unal, st;
        a = s; got = 0; t = 0; st = 0; unal = (s % 8) != 0;
        while (t < ticks && got < limit) begin
            if (unal && got > 0 && (a % 8) == 0 && !st) begin
                ex.push_back(-1); st = 1;
            end else begin
                ex.push_back(a); st = 0; got++; a = (a + 1) & MASK;
            end
            t++;
        end
    endtask

    task automatic compare(input string req);
        check({req, " count"}, ev.size(), ex.size());
        for (int i = 0; i < ex.size() && i < ev.size(); i++)
            check(req, ev[i], ex[i]);
    endtask

    task automatic t_reset;
        check("R1 rdata", int'(cfg_rdata), 'h00C1);
        check("R1 valid", int'(valid), 0);
        check("R1 wait", int'(wait_o), 0);
        check("R1 illegal", int'(cfg_illegal), 0);
    endtask

    task automatic t_reserved;
        write_cfg(16'hFFFF);
        check("R2 reserved read", int'(cfg_rdata), 'h00CF);
        write_cfg(16'h0430);
        check("R2 reserved only", int'(cfg_rdata), 'h0000);
    endtask

    task automatic t_seq_wrap;
        write_cfg(16'h00C1);
        do_start('h12346); bclk_cycles(6);
        exp_wrap('h12346, 4, 1); compare("R4 seq wrap4");
        write_cfg(16'h00C2);
        do_start('h00005); bclk_cycles(10);
        exp_wrap('h00005, 8, 1); compare("R4 seq wrap8");
    endtask

    task automatic t_interleaved;
        write_cfg(16'h0042);
        do_start('h00013); bclk_cycles(10);
        exp_wrap('h00013, 8, 0); compare("R5 intl8");
        write_cfg(16'h0041);
        do_start('h3ABC6); bclk_cycles(6);
        exp_wrap('h3ABC6, 4, 0); compare("R5 intl4");
    endtask

    task automatic t_nowrap;
        write_cfg(16'h00CA);
        do_start('h00006); bclk_cycles(12);
        exp_linear('h00006, 12, 8); compare("R6 R9 nowrap8 unaligned");
        write_cfg(16'h00C9);
        do_start('h00040); bclk_cycles(7);
        exp_linear('h00040, 7, 4); compare("R6 R8 nowrap4 aligned");
    endtask

    task automatic t_continuous;
        write_cfg(16'h00C7);
        do_start('h00010); bclk_cycles(20);
        exp_linear('h00010, 20, 1000); compare("R7 R8 cont aligned");
        do_start('h7FFFD); bclk_cycles(22);
        exp_linear('h7FFFD, 22, 1000); compare("R7 R9 cont unaligned wrap");
    endtask

    task automatic t_edge;
        write_cfg(16'h00C1);
        do_start('h00100);
        bclk = 1'b1; repeat (6) @(negedge clk);
        check("R3 rising delivers", ev.size(), 1);
        bclk = 1'b0; repeat (6) @(negedge clk);
        check("R3 falling ignored", ev.size(), 1);
        bclk_cycles(4);
        write_cfg(16'h0081);
        do_start('h00100);
        bclk = 1'b1; repeat (6) @(negedge clk);
        check("R3 rising ignored", ev.size(), 0);
        bclk = 1'b0; repeat (6) @(negedge clk);
        check("R3 falling delivers", ev.size(), 1);
        bclk_cycles(4);
    endtask

    task automatic t_illegal;
        write_cfg(16'h00C3);
        check("R10 bad length flag", int'(cfg_illegal), 1);
        do_start('h00020); bclk_cycles(4);
        check("R10 bad length ignored", ev.size(), 0);
        write_cfg(16'h0047);
        check("R10 cont intl flag", int'(cfg_illegal), 1);
        do_start('h00020); bclk_cycles(4);
        check("R10 cont intl ignored", ev.size(), 0);
    endtask

    task automatic t_abort;
        write_cfg(16'h00C2);
        do_start('h00020); bclk_cycles(3);
        exp_wrap('h00020, 8, 1);
        while (ex.size() > 3) void'(ex.pop_back());
        compare("R11 first burst");
        do_start('h00043); bclk_cycles(10);
        exp_wrap('h00043, 8, 1); compare("R11 restarted burst");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reserved();
        t_seq_wrap();
        t_interleaved();
        t_nowrap();
        t_continuous();
        t_edge();
        t_illegal();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule